// File: doc/BRIEF.md
# Per-Master Aperture Address Remapper

This block sits in front of a multi-master interconnect and decides, for each master separately, which slave port an access goes to and which physical address it carries. The 32-bit address space is cut into sixteen 256 MB apertures by the top address nibble. For every master the block holds two 64-bit packed words:

- a routing word of sixteen 4-bit slave codes;
- a translation word of sixteen 4-bit replacement nibbles.

The decode path is purely combinational. It returns a slave code and a valid flag, or a decode-error flag when the code is zero. It also returns the address with its top nibble replaced.

Software programs the block through a flat register port, one 32-byte window per master. Writes land in shadow registers and take no effect until the master's commit register receives the value 1. On that clock edge the whole shadow set is copied into the active set that the decoder uses, so a master never sees a half-written mapping.

Master 0 also carries a two-bit boot-mirror field. While the field is nonzero, aperture 0 of master 0 is forced onto the boot ROM port with its address left untranslated. Reset values reproduce the power-on map:

| Masters | Slave code | Aperture n translates to |
|---|---|---|
| All but the last | 7 everywhere | (n+8) mod 16 |
| Last (power-management) | 6 for aperture 15, 0 elsewhere | 0 |

Top module: `aper_remap`

## Requirements
- R1: After reset, every master except the last has routing word 0x77777777_77777777 and translation word 0x76543210_FEDCBA98. The last master has routing word 0x60000000_00000000 and translation word 0. The boot-mirror field resets to 1. All of these read back through the register port.
- R2: An address whose bits [31:28] equal n is routed to the slave code held in nibble n of the active routing word. The routing word is {high word at +0x04, low word at +0x00}, and nibble n is bits [4n+3:4n].
- R3: The translated address is nibble n of the active translation word {high at +0x0C, low at +0x08}, concatenated with the incoming address bits [27:0].
- R4: A slave code of 0 raises that master's decode-error flag, clears its valid flag and drives slave code 0. Any nonzero code sets valid and clears the error flag.
- R5: A write to a routing or translation word is readable at once from the same offset, but decoding keeps using the previous mapping.
- R6: Writing exactly 1 to a master's commit register (+0x14) copies its shadow words into the active words on that clock edge. Any other value written there leaves the active words unchanged. The commit register reads as 0.
- R7: A commit for one master leaves every other master's active mapping unchanged, even when that other master has pending shadow writes.
- R8: The boot-mirror field sits at absolute offset 0x010 (bits [1:0]) and acts as soon as it is written. While it is nonzero, master 0's aperture 0 routes to slave code 5 with the address untranslated. Once it is cleared, the programmed mapping applies.
- R9: Writes to undefined offsets are ignored and reads from them return 0. Undefined offsets are +0x10 of any master other than 0, +0x18 and +0x1C of every master, and anything above the last master's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte address (master index in [8:5], offset in [4:0]) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| mst_addr | input | 384 | Per-master incoming address, master m in bits [32m+31:32m] |
| slv_sel | output | 48 | Per-master slave code, master m in bits [4m+3:4m] |
| slv_vld | output | 12 | Per-master slave-select valid |
| dec_err | output | 12 | Per-master decode error (slave code 0) |
| xlat_addr | output | 384 | Per-master translated address |

## Verification
The reset map is tried at the lowest, a middle and the top aperture of an ordinary master. This separates nibble-order mistakes (nibble n against nibble 15-n), because the default translation is a rotation by eight. The power-management master is probed at aperture 15 and at neighbouring zero-code apertures, which tells a correct error path apart from a routing that only looks at one select word.

One master is then reprogrammed with distinct codes per nibble. It is probed before a commit, after a commit with the wrong value and after a proper commit, while a second master carries pending shadow writes. This keeps shadow leakage, over-eager commits and cross-master commits apart.

The boot mirror is checked at aperture 0 of master 0 before and after clearing, and against the same offset in another master's window.

// File: rtl/amap_pkg.sv
package amap_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned APER_N   = 1 << NIB_W;
  localparam int unsigned MAP_W    = APER_N * NIB_W;
  localparam int unsigned WIN_BITS = 5;
  localparam logic [NIB_W-1:0] ROM_CODE = 4'd5;

  localparam logic [MAP_W-1:0] SEL_STD  = 64'h7777_7777_7777_7777;
  localparam logic [MAP_W-1:0] OFS_STD  = 64'h7654_3210_FEDC_BA98;
  localparam logic [MAP_W-1:0] SEL_PWR  = 64'h6000_0000_0000_0000;
  localparam logic [MAP_W-1:0] OFS_PWR  = '0;

  function automatic logic [NIB_W-1:0] nib_pick(input logic [MAP_W-1:0] w,
                                                input logic [NIB_W-1:0] n);
    return w[n*NIB_W +: NIB_W];
  endfunction

  function automatic logic [ADDR_W-1:0] xlat(input logic [ADDR_W-1:0] a,
                                             input logic [NIB_W-1:0] top);
    return {top, a[ADDR_W-NIB_W-1:0]};
  endfunction
endpackage

// File: rtl/amap_regbank.sv
module amap_regbank
  import amap_pkg::*;
#(
  parameter int unsigned NUM_MST  = 12,
  parameter logic [1:0]  BOOT_RST = 2'b01,
  localparam int unsigned MW      = $clog2(NUM_MST),
  localparam int unsigned CFG_AW  = MW + WIN_BITS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [31:0]                   cfg_wdata,
  output logic [31:0]                   cfg_rdata,
  output logic [NUM_MST-1:0][MAP_W-1:0] sh_sel,
  output logic [NUM_MST-1:0][MAP_W-1:0] sh_ofs,
  output logic [NUM_MST-1:0][MAP_W-1:0] act_sel,
  output logic [NUM_MST-1:0][MAP_W-1:0] act_ofs,
  output logic [NUM_MST-1:0]            upd_hit,
  output logic [1:0]                    boot_mirror
);
  logic [MW-1:0]       idx;
  logic [WIN_BITS-1:0] off;
  logic                in_range;
  logic                boot_hit;

  assign idx      = cfg_addr[CFG_AW-1:WIN_BITS];
  assign off      = cfg_addr[WIN_BITS-1:0];
  assign in_range = {1'b0, idx} < (MW+1)'(NUM_MST);
  assign boot_hit = cfg_we && (idx == '0) && (off == 5'h10);

  for (genvar m = 0; m < NUM_MST; m++) begin : g_upd
    assign upd_hit[m] = cfg_we && in_range && (idx == MW'(m)) &&
                        (off == 5'h14) && (cfg_wdata == 32'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < NUM_MST; m++) begin
        sh_sel[m]  <= (m == NUM_MST-1) ? SEL_PWR : SEL_STD;
        sh_ofs[m]  <= (m == NUM_MST-1) ? OFS_PWR : OFS_STD;
        act_sel[m] <= (m == NUM_MST-1) ? SEL_PWR : SEL_STD;
        act_ofs[m] <= (m == NUM_MST-1) ? OFS_PWR : OFS_STD;
      end
      boot_mirror <= BOOT_RST;
    end else begin
      for (int m = 0; m < NUM_MST; m++) begin
        if (cfg_we && in_range && idx == MW'(m)) begin
          case (off)
            5'h00: sh_sel[m][31:0]  <= cfg_wdata;
            5'h04: sh_sel[m][63:32] <= cfg_wdata;
            5'h08: sh_ofs[m][31:0]  <= cfg_wdata;
            5'h0C: sh_ofs[m][63:32] <= cfg_wdata;
            default: ;
          endcase
        end
        if (upd_hit[m]) begin
          act_sel[m] <= sh_sel[m];
          act_ofs[m] <= sh_ofs[m];
        end
      end
      if (boot_hit) boot_mirror <= cfg_wdata[1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (in_range) begin
      case (off)
        5'h00: cfg_rdata = sh_sel[idx][31:0];
        5'h04: cfg_rdata = sh_sel[idx][63:32];
        5'h08: cfg_rdata = sh_ofs[idx][31:0];
        5'h0C: cfg_rdata = sh_ofs[idx][63:32];
        5'h10: if (idx == '0) cfg_rdata = {30'd0, boot_mirror};
        default: cfg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/amap_dec.sv
module amap_dec
  import amap_pkg::*;
#(
  parameter bit HAS_MIRROR = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [MAP_W-1:0]  sel_w,
  input  logic [MAP_W-1:0]  ofs_w,
  input  logic              mirror_on,
  output logic [NIB_W-1:0]  code,
  output logic              vld,
  output logic              err,
  output logic [ADDR_W-1:0] xaddr
);
  logic [NIB_W-1:0] aper;
  logic [NIB_W-1:0] raw_code;
  logic             mirrored;

  assign aper     = addr[ADDR_W-1 -: NIB_W];
  assign raw_code = nib_pick(sel_w, aper);
  assign mirrored = HAS_MIRROR && mirror_on && (aper == '0);

  always_comb begin
    if (mirrored) begin
      code  = ROM_CODE;
      xaddr = addr;
    end else begin
      code  = raw_code;
      xaddr = xlat(addr, nib_pick(ofs_w, aper));
    end
    vld = (code != '0);
    err = (code == '0);
  end
endmodule

// File: rtl/aper_remap.sv
module aper_remap
  import amap_pkg::*;
#(
  parameter int unsigned NUM_MST  = 12,
  parameter logic [1:0]  BOOT_RST = 2'b01,
  localparam int unsigned CFG_AW  = $clog2(NUM_MST) + WIN_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  input  logic [NUM_MST*ADDR_W-1:0] mst_addr,
  output logic [NUM_MST*NIB_W-1:0]  slv_sel,
  output logic [NUM_MST-1:0]        slv_vld,
  output logic [NUM_MST-1:0]        dec_err,
  output logic [NUM_MST*ADDR_W-1:0] xlat_addr
);
  logic [NUM_MST-1:0][MAP_W-1:0] sh_sel, sh_ofs, act_sel, act_ofs;
  logic [NUM_MST-1:0]            upd_hit;
  logic [1:0]                    boot_mirror;
  logic                          mirror_on;

  assign mirror_on = (boot_mirror != 2'b00);

  amap_regbank #(.NUM_MST(NUM_MST), .BOOT_RST(BOOT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sh_sel(sh_sel), .sh_ofs(sh_ofs), .act_sel(act_sel), .act_ofs(act_ofs),
    .upd_hit(upd_hit), .boot_mirror(boot_mirror)
  );

  for (genvar m = 0; m < NUM_MST; m++) begin : g_dec
    amap_dec #(.HAS_MIRROR(m == 0)) u_dec (
      .addr     (mst_addr[m*ADDR_W +: ADDR_W]),
      .sel_w    (act_sel[m]),
      .ofs_w    (act_ofs[m]),
      .mirror_on(mirror_on),
      .code     (slv_sel[m*NIB_W +: NIB_W]),
      .vld      (slv_vld[m]),
      .err      (dec_err[m]),
      .xaddr    (xlat_addr[m*ADDR_W +: ADDR_W])
    );
  end
endmodule

// File: rtl/aper_remap_chk.sv
module aper_remap_chk
  import amap_pkg::*;
#(
  parameter int unsigned NUM_MST = 12,
  localparam int unsigned CFG_AW = $clog2(NUM_MST) + WIN_BITS
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [CFG_AW-1:0]             cfg_addr,
  input logic [31:0]                   cfg_rdata,
  input logic [NUM_MST*ADDR_W-1:0]     mst_addr,
  input logic [NUM_MST*NIB_W-1:0]      slv_sel,
  input logic [NUM_MST-1:0]            slv_vld,
  input logic [NUM_MST-1:0]            dec_err,
  input logic [NUM_MST*ADDR_W-1:0]     xlat_addr,
  input logic [NUM_MST-1:0][MAP_W-1:0] sh_sel,
  input logic [NUM_MST-1:0][MAP_W-1:0] sh_ofs,
  input logic [NUM_MST-1:0][MAP_W-1:0] act_sel,
  input logic [NUM_MST-1:0][MAP_W-1:0] act_ofs,
  input logic [NUM_MST-1:0]            upd_hit,
  input logic [1:0]                    boot_mirror
);
  for (genvar m = 0; m < NUM_MST; m++) begin : g_chk
    p_err_novld_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dec_err[m] |-> (!slv_vld[m] && slv_sel[m*NIB_W +: NIB_W] == '0));
    p_vld_noerr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      slv_vld[m] |-> (!dec_err[m] && slv_sel[m*NIB_W +: NIB_W] != '0));
    p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_addr[m*ADDR_W +: ADDR_W-NIB_W] == mst_addr[m*ADDR_W +: ADDR_W-NIB_W]);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_hit[m] |=> ($stable(act_sel[m]) && $stable(act_ofs[m])));
    p_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd_hit[m] |=> (act_sel[m] == $past(sh_sel[m]) && act_ofs[m] == $past(sh_ofs[m])));
  end

  p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_mirror != 2'b00 && mst_addr[ADDR_W-1 -: NIB_W] == '0) |->
      (slv_sel[NIB_W-1:0] == ROM_CODE && xlat_addr[ADDR_W-1:0] == mst_addr[ADDR_W-1:0]));
  p_undef_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[WIN_BITS-1:0] inside {5'h14, 5'h18, 5'h1C}) |-> cfg_rdata == 32'd0);
endmodule

bind aper_remap aper_remap_chk #(.NUM_MST(NUM_MST)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .mst_addr(mst_addr), .slv_sel(slv_sel), .slv_vld(slv_vld), .dec_err(dec_err),
  .xlat_addr(xlat_addr), .sh_sel(sh_sel), .sh_ofs(sh_ofs), .act_sel(act_sel),
  .act_ofs(act_ofs), .upd_hit(upd_hit), .boot_mirror(boot_mirror)
);

// File: tb/aper_remap_test.sv
module aper_remap_test;
  localparam int NM = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [8:0]      cfg_addr = '0;
  logic [31:0]     cfg_wdata = '0;
  logic [31:0]     cfg_rdata;
  logic [NM*32-1:0] mst_addr = '0;
  logic [NM*4-1:0]  slv_sel;
  logic [NM-1:0]    slv_vld, dec_err;
  logic [NM*32-1:0] xlat_addr;

  int errors = 0;
  int checks = 0;

  aper_remap uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mst_addr(mst_addr),
    .slv_sel(slv_sel), .slv_vld(slv_vld), .dec_err(dec_err), .xlat_addr(xlat_addr)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0]  m;
    logic [31:0] a;
    logic [3:0]  s;
    logic        v;
    logic        e;
    logic [31:0] x;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0,  32'h0000_1234, 4'd5, 1'b1, 1'b0, 32'h0000_1234},
    '{4'd0,  32'h3ABC_DEF0, 4'd7, 1'b1, 1'b0, 32'hBABC_DEF0},
    '{4'd0,  32'hF000_0004, 4'd7, 1'b1, 1'b0, 32'h7000_0004},
    '{4'd5,  32'h0000_0010, 4'd7, 1'b1, 1'b0, 32'h8000_0010},
    '{4'd2,  32'h8000_00FF, 4'd7, 1'b1, 1'b0, 32'h0000_00FF},
    '{4'd11, 32'hF100_0000, 4'd6, 1'b1, 1'b0, 32'h0100_0000},
    '{4'd11, 32'h2000_0000, 4'd0, 1'b0, 1'b1, 32'h0000_0000},
    '{4'd11, 32'hE000_0000, 4'd0, 1'b0, 1'b1, 32'h0000_0000}
  };

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [8:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%03h: got 0x%08h expected 0x%08h", req, a, cfg_rdata, exp);
    end
  endtask

  task automatic dchk(input string req, input int m, input logic [31:0] a,
                      input logic [3:0] es, input logic ev, input logic ee,
                      input logic [31:0] ex);
    mst_addr[m*32 +: 32] = a;
    #1;
    checks++;
    if (slv_sel[m*4 +: 4] !== es || slv_vld[m] !== ev || dec_err[m] !== ee ||
        xlat_addr[m*32 +: 32] !== ex) begin
      errors++;
      $display("FAIL %s m%0d addr 0x%08h: got sel=%0d vld=%b err=%b x=0x%08h expected sel=%0d vld=%b err=%b x=0x%08h",
               req, m, a, slv_sel[m*4 +: 4], slv_vld[m], dec_err[m], xlat_addr[m*32 +: 32],
               es, ev, ee, ex);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state read back
    rchk("R1", 9'h000, 32'h7777_7777);
    rchk("R1", 9'h00C, 32'h7654_3210);
    rchk("R1", 9'h164, 32'h6000_0000);
    rchk("R1", 9'h168, 32'h0000_0000);
    rchk("R1", 9'h010, 32'h0000_0001);
    // R1 R2 R3 R4 R8 default map table
    for (int i = 0; i < 8; i++)
      dchk("R2/R3/R4 table", int'(VECS[i].m), VECS[i].a, VECS[i].s, VECS[i].v,
           VECS[i].e, VECS[i].x);

    // R5 shadow write visible, decode unchanged
    wr(9'h060, 32'h0000_0021);
    rchk("R5", 9'h060, 32'h0000_0021);
    dchk("R5", 3, 32'h0000_0000, 4'd7, 1'b1, 1'b0, 32'h8000_0000);
    // R6 wrong commit value ignored
    wr(9'h074, 32'h0000_0002);
    dchk("R6", 3, 32'h1000_0000, 4'd7, 1'b1, 1'b0, 32'h9000_0000);
    rchk("R6", 9'h074, 32'h0000_0000);
    // R7 pending shadow on master 4
    wr(9'h080, 32'h0000_0003);
    // R6 proper commit
    wr(9'h074, 32'h0000_0001);
    dchk("R6", 3, 32'h0000_0000, 4'd1, 1'b1, 1'b0, 32'h8000_0000);
    dchk("R2", 3, 32'h1000_0000, 4'd2, 1'b1, 1'b0, 32'h9000_0000);
    dchk("R4", 3, 32'h2345_6789, 4'd0, 1'b0, 1'b1, 32'hA345_6789);
    dchk("R7", 4, 32'h0000_0000, 4'd7, 1'b1, 1'b0, 32'h8000_0000);
    // R3 custom translation nibble via high offset word
    wr(9'h06C, 32'hA000_0000);
    wr(9'h074, 32'h0000_0001);
    dchk("R3", 3, 32'hF000_0ABC, 4'd7, 1'b1, 1'b0, 32'hA000_0ABC);
    dchk("R7", 4, 32'h0000_0000, 4'd7, 1'b1, 1'b0, 32'h8000_0000);
    // R8 clear boot mirror, takes effect without commit
    wr(9'h010, 32'h0000_0000);
    rchk("R8", 9'h010, 32'h0000_0000);
    dchk("R8", 0, 32'h0000_1234, 4'd7, 1'b1, 1'b0, 32'h8000_1234);
    // R9 undefined offsets
    wr(9'h030, 32'h0000_0003);
    rchk("R9", 9'h030, 32'h0000_0000);
    dchk("R9", 0, 32'h0000_0040, 4'd7, 1'b1, 1'b0, 32'h8000_0040);
    dchk("R9", 1, 32'h0000_0000, 4'd7, 1'b1, 1'b0, 32'h8000_0000);
    wr(9'h038, 32'hFFFF_FFFF);
    rchk("R9", 9'h038, 32'h0000_0000);
    wr(9'h180, 32'h1234_5678);
    rchk("R9", 9'h180, 32'h0000_0000);
    rchk("R9", 9'h020, 32'h7777_7777);
    rchk("R9", 9'h01C, 32'h0000_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule